// File: doc/BRIEF.md
# Pipelined Fixed-Point Exponential with Divide-by-Six Range Reduction

This block computes e^x for signed fixed-point arguments from -6 to just under +6. It accepts one new argument on every clock edge and never stalls. Each result appears a fixed number of cycles after its argument. Arguments outside the legal span are first pinned to the nearest legal value.

The argument is then multiplied by a rounded constant for one sixth, which brings it into [-1, 1). A 64-segment table with linear interpolation evaluates the exponential on that short interval. The interpolated value y is raised to the sixth power in three multiply stages: y², then y²·y, then that cube squared.

The design has no iteration anywhere, so the result rate equals the argument rate. An accompanying valid bit travels down the pipeline beside the data.

Top module: `exp6_pipe`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 7 clock cycles. An argument sampled at the end of cycle c yields its result in cycle c+7.
- R2: While `rst` is high and in the cycle after it, `out_valid` is 0.
- R3: `in_data` is two's complement with 12 fractional bits (value = raw/4096). `out_data` is unsigned with 22 fractional bits (value = raw/2^22). For a legal argument the result lies within 0.1 % (relative) of e^x.
- R4: A raw argument of 24576 (6.0) or larger produces the same `out_data` as raw 24575 (6 − 2^-12).
- R5: A raw argument below -24576 (below -6.0) produces the same `out_data` as raw -24576 (-6.0).
- R6: Arguments may be presented on consecutive cycles with any pattern of gaps. Every accepted argument yields exactly one result, in arrival order, and no result appears without an argument.
- R7: An argument of 0 produces exactly 0x0040_0000 (1.0).
- R8: The output is monotonic: a larger clamped argument never gives a smaller `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Argument on `in_data` is present this cycle |
| in_data | input | 16 | Signed argument, 12 fractional bits |
| out_valid | output | 1 | Result on `out_data` is present this cycle |
| out_data | output | 32 | Unsigned e^x, 22 fractional bits |

## Verification
The bench probes the clamp edges, where the pin of +6 sits one LSB below the limit. A broken comparison would let 6.0 or -6.000244 through to a different result, or would clamp the legal value -6.0 itself.

The zero argument is checked bit-exact, which catches any offset error in the table index or any bias in the multiplier truncation. A dense ascending sweep crosses every table segment boundary, where a wrong slope or a shifted fraction field shows up as an error above 0.1 % or as a step down.

Arguments are sent with irregular gaps. A valid chain of the wrong length, or one that drops or duplicates an item, appears as a latency mismatch, an unmatched result or a leftover expected entry.

// File: rtl/exp6_pkg.sv
package exp6_pkg;
  localparam int IN_W      = 16;
  localparam int IN_FRAC   = 12;
  localparam int LIMIT     = 6;
  localparam int X_HI      = (LIMIT << IN_FRAC) - 1;
  localparam int X_LO      = -(LIMIT << IN_FRAC);

  localparam int K_FRAC    = 20;
  localparam int K_W       = 18;
  localparam int K_CONST   = (1 << K_FRAC) / LIMIT;
  localparam int R_FRAC    = 18;
  localparam int U_W       = R_FRAC + 1;
  localparam int SHIFT     = IN_FRAC + K_FRAC - R_FRAC;
  localparam int XP_W      = IN_W + K_W + 1;

  localparam int LUT_BITS  = 6;
  localparam int LUT_N     = 1 << LUT_BITS;
  localparam int SEG_BITS  = U_W - LUT_BITS;
  localparam int TERM_FRAC = 40;
  localparam int SERIES_N  = 24;

  localparam int Y_FRAC    = 22;
  localparam int Y_W       = Y_FRAC + 2;
  localparam int Y2_W      = Y_FRAC + 4;
  localparam int Y3_W      = Y_FRAC + 5;
  localparam int OUT_W     = 32;
  localparam int LATENCY   = 7;

  // Pin an argument into [X_LO, X_HI].
  function automatic logic signed [IN_W-1:0] sat_input(input logic [IN_W-1:0] raw);
    if ($signed(raw) > X_HI)      return IN_W'(X_HI);
    else if ($signed(raw) < X_LO) return IN_W'(X_LO);
    else                          return $signed(raw);
  endfunction

  // Table knot i holds e^((i - N/2) / (N/2)), evaluated by an integer series.
  function automatic logic [Y_W-1:0] lut_entry(input int i);
    longint acc;
    longint term;
    term = longint'(1) <<< TERM_FRAC;
    acc  = term;
    for (int k = 1; k <= SERIES_N; k++) begin
      term = (term * longint'(i - LUT_N / 2)) / longint'((LUT_N / 2) * k);
      acc  = acc + term;
    end
    return Y_W'((acc + (longint'(1) <<< (TERM_FRAC - Y_FRAC - 1))) >>> (TERM_FRAC - Y_FRAC));
  endfunction
endpackage

// File: rtl/exp6_reduce.sv
module exp6_reduce
  import exp6_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [IN_W-1:0]        in_data,
  output logic                   sat_valid,
  output logic signed [IN_W-1:0] x_sat,
  output logic                   u_valid,
  output logic [U_W-1:0]         u_red
);
  logic signed [XP_W-1:0] prod;
  logic [U_W-1:0]         u_next;

  always_ff @(posedge clk) begin
    sat_valid <= rst ? 1'b0 : in_valid;
    x_sat     <= sat_input(in_data);
  end

  // x * (1/6) then offset by +1 so the index field is unsigned.
  assign prod   = XP_W'(x_sat) * XP_W'($signed({1'b0, K_W'(K_CONST)}));
  assign u_next = U_W'((prod >>> SHIFT) + (XP_W'(1) <<< R_FRAC));

  always_ff @(posedge clk) begin
    u_valid <= rst ? 1'b0 : sat_valid;
    u_red   <= u_next;
  end
endmodule

// File: rtl/exp6_core.sv
module exp6_core
  import exp6_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               u_valid,
  input  logic [U_W-1:0]     u_red,
  output logic               y_valid,
  output logic [Y_W-1:0]     y_core
);
  localparam int IP_W = Y_W + SEG_BITS;

  logic [Y_W-1:0]      lut [LUT_N+1];
  logic [LUT_BITS:0]   idx;
  logic [SEG_BITS-1:0] frac;
  logic                seg_valid;
  logic [Y_W-1:0]      base;
  logic [Y_W-1:0]      slope;
  logic [SEG_BITS-1:0] frac_q;
  logic [IP_W-1:0]     step;

  for (genvar g = 0; g <= LUT_N; g++) begin : g_knot
    assign lut[g] = lut_entry(g);
  end

  assign idx  = {1'b0, u_red[U_W-1 -: LUT_BITS]};
  assign frac = u_red[SEG_BITS-1:0];

  always_ff @(posedge clk) begin
    seg_valid <= rst ? 1'b0 : u_valid;
    base      <= lut[idx];
    slope     <= lut[idx + 1'b1] - lut[idx];
    frac_q    <= frac;
  end

  assign step = IP_W'(slope) * IP_W'(frac_q);

  always_ff @(posedge clk) begin
    y_valid <= rst ? 1'b0 : seg_valid;
    y_core  <= base + Y_W'(step >> SEG_BITS);
  end
endmodule

// File: rtl/exp6_mulq.sv
module exp6_mulq
  import exp6_pkg::*;
#(
  parameter int A_W = 24,
  parameter int B_W = 24,
  parameter int P_W = 26
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           out_valid,
  output logic [P_W-1:0] p
);
  localparam int PR_W = A_W + B_W;
  logic [PR_W-1:0] prod;

  assign prod = PR_W'(a) * PR_W'(b);

  always_ff @(posedge clk) begin
    out_valid <= rst ? 1'b0 : in_valid;
    p         <= P_W'(prod >> Y_FRAC);
  end
endmodule

// File: rtl/exp6_pow6.sv
module exp6_pow6
  import exp6_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             y_valid,
  input  logic [Y_W-1:0]   y_core,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic            v2;
  logic            v3;
  logic [Y2_W-1:0] y2;
  logic [Y3_W-1:0] y3;
  logic [Y_W-1:0]  y_d;

  always_ff @(posedge clk) y_d <= y_core;

  exp6_mulq #(.A_W(Y_W), .B_W(Y_W), .P_W(Y2_W)) u_sq (
    .clk(clk), .rst(rst), .in_valid(y_valid), .a(y_core), .b(y_core),
    .out_valid(v2), .p(y2)
  );

  exp6_mulq #(.A_W(Y2_W), .B_W(Y_W), .P_W(Y3_W)) u_cube (
    .clk(clk), .rst(rst), .in_valid(v2), .a(y2), .b(y_d),
    .out_valid(v3), .p(y3)
  );

  exp6_mulq #(.A_W(Y3_W), .B_W(Y3_W), .P_W(OUT_W)) u_sixth (
    .clk(clk), .rst(rst), .in_valid(v3), .a(y3), .b(y3),
    .out_valid(out_valid), .p(out_data)
  );
endmodule

// File: rtl/exp6_pipe.sv
module exp6_pipe
  import exp6_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic                   sat_valid;
  logic signed [IN_W-1:0] x_sat;
  logic                   u_valid;
  logic [U_W-1:0]         u_red;
  logic                   y_valid;
  logic [Y_W-1:0]         y_core;

  exp6_reduce u_reduce (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .sat_valid(sat_valid), .x_sat(x_sat), .u_valid(u_valid), .u_red(u_red)
  );

  exp6_core u_core (
    .clk(clk), .rst(rst), .u_valid(u_valid), .u_red(u_red),
    .y_valid(y_valid), .y_core(y_core)
  );

  exp6_pow6 u_pow (
    .clk(clk), .rst(rst), .y_valid(y_valid), .y_core(y_core),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/exp6_chk.sv
module exp6_chk
  import exp6_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [IN_W-1:0]        in_data,
  input logic                   sat_valid,
  input logic signed [IN_W-1:0] x_sat,
  input logic                   y_valid,
  input logic [Y_W-1:0]         y_core,
  input logic                   out_valid,
  input logic [OUT_W-1:0]       out_data
);
  localparam logic [Y_W-1:0]   Y_MIN   = 24'd1_540_000;
  localparam logic [Y_W-1:0]   Y_MAX   = 24'd11_402_000;
  localparam logic [OUT_W-1:0] OUT_MIN = 32'd10_000;
  localparam logic [OUT_W-1:0] OUT_MAX = 32'd1_693_000_000;

  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst < 4'(LATENCY)) since_rst <= since_rst + 1'b1;
  end

  // R1
  latency_match_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY)));

  // R2
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R4
  clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ($signed(in_data) > X_HI)) |=> (sat_valid && (x_sat == IN_W'(X_HI))));

  // R5
  clamp_low_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ($signed(in_data) < X_LO)) |=> (sat_valid && (x_sat == IN_W'(X_LO))));

  // R3
  core_span_chk: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> ((y_core >= Y_MIN) && (y_core <= Y_MAX)));

  // R3
  out_span_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data >= OUT_MIN) && (out_data <= OUT_MAX)));
endmodule

bind exp6_pipe exp6_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .sat_valid(sat_valid), .x_sat(x_sat), .y_valid(y_valid), .y_core(y_core),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/exp6_pipe_tb.sv
module exp6_pipe_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  exp6_pipe u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { real xr; int stamp; int seq; } item_t;
  item_t       sbq[$];
  logic [31:0] res[int];
  int nsent = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic real clamp_real(input logic [15:0] raw);
    int v;
    v = int'($signed(raw));
    if (v > 24575) v = 24575;
    if (v < -24576) v = -24576;
    return real'(v) / 4096.0;
  endfunction

  task automatic send(input logic [15:0] raw);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = raw;
    it.xr = clamp_real(raw);
    it.stamp = cyc;
    it.seq = nsent;
    sbq.push_back(it);
    nsent++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'h5a5a;
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R6", $sformatf("result %h with nothing pending, expected none", out_data));
      end else begin
        item_t it;
        real got, want, rel;
        it = sbq.pop_front();
        // R1: seven cycles after acceptance
        check(cyc - it.stamp == 7, "R1",
              $sformatf("seq %0d latency actual %0d expected 7", it.seq, cyc - it.stamp));
        got  = real'(out_data) / 4194304.0;
        want = $exp(it.xr);
        rel  = (got > want ? got - want : want - got) / want;
        // R3: relative error bound
        check(rel <= 1.0e-3, "R3",
              $sformatf("x=%f actual %f expected %f", it.xr, got, want));
        res[it.seq] = out_data;
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int sw_first;
    int sw_last;
    // R2: quiet during and right after reset
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R2", $sformatf("in reset out_valid actual %b expected 0", out_valid));
    end
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R2", $sformatf("after reset out_valid actual %b expected 0", out_valid));
    end

    send(16'h0000);                 // seq 0
    idle(10);

    send(16'd24575);                // seq 1
    send(16'd24576);                // seq 2
    send(16'h7fff);                 // seq 3
    send(16'(-24576));              // seq 4
    send(16'(-24577));              // seq 5
    send(16'h8000);                 // seq 6
    idle(3);

    sw_first = nsent;
    for (int v = -24576, k = 0; v <= 24575; v += 61, k++) begin
      send(16'(v));
      if (k % 7 == 3) idle(1);
      if (k % 23 == 11) idle(2);
    end
    sw_last = nsent - 1;

    for (int k = 0; k < 200; k++) begin
      send(16'($urandom));
      if (k % 5 == 2) idle(1);
    end
    idle(15);

    // R7: exact unity at zero
    check(res.exists(0) && res[0] == 32'h0040_0000, "R7",
          $sformatf("exp(0) actual %h expected 00400000", res.exists(0) ? res[0] : 32'hx));
    // R4: high clamp
    check(res[2] == res[1], "R4", $sformatf("6.0 actual %h expected %h", res[2], res[1]));
    check(res[3] == res[1], "R4", $sformatf("max raw actual %h expected %h", res[3], res[1]));
    // R5: low clamp
    check(res[5] == res[4], "R5", $sformatf("below -6 actual %h expected %h", res[5], res[4]));
    check(res[6] == res[4], "R5", $sformatf("min raw actual %h expected %h", res[6], res[4]));
    // R8: ascending sweep never steps down
    for (int i = sw_first + 1; i <= sw_last; i++) begin
      check(res[i] >= res[i-1], "R8",
            $sformatf("seq %0d actual %h expected >= %h", i, res[i], res[i-1]));
    end
    // R6: one result per argument
    check(sbq.size() == 0, "R6", $sformatf("pending actual %0d expected 0", sbq.size()));
    check(res.num() == nsent, "R6", $sformatf("results actual %0d expected %0d", res.num(), nsent));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule